// File: doc/BRIEF.md
# Masked Sticky-Pending Interrupt Controller

This block merges a bank of level-sensitive interrupt request lines into a single interrupt request for a processor core. Each line is first brought into the clock domain through a short synchronizer chain. A sticky pending register latches every line that is seen high. An enable mask chooses which pending bits may raise the output. The core acknowledges an interrupt by writing ones to the pending register. A line that is still held high sets its bit again at once, so an acknowledge only takes effect after the source has dropped its request.

Each line also has a wide event counter. The counter advances once per rising edge of the synchronized line and can be read back in two halves. All state sits behind one plain synchronous register port: a write strobe with an address and data, and a combinational read path selected by the same address.

Top module: `irq_pending_ctrl`

## Requirements
- R1: A line that goes high sets its pending bit on the third rising clock edge after the change, because it passes two synchronizer stages and one register. The bit stays set after the line drops.
- R2: `irqOut` is registered. It is high one cycle after pending AND mask is nonzero, and low one cycle after that AND is zero.
- R3: A write to address 1 clears every pending bit whose written bit is 1 and leaves the bits written as 0 unchanged.
- R4: A synchronized line that is high at the moment of an acknowledge keeps its pending bit set. This includes the cycle in which the line first appears.
- R5: A write to address 0 replaces the whole mask. Reading address 0 or 1 returns the mask or the pending value and changes no state.
- R6: Reset clears the mask, the pending bits, the synchronized levels, every counter and `irqOut`.
- R7: A line's counter advances by one on each rising edge of its synchronized level. A line held high for many cycles counts only once.
- R8: A counter that reaches its maximum value wraps to zero on the next rising edge.
- R9: Address 2 reads the synchronized line levels. Address 2*NUM_LINES + 2*n + h reads counter n, with h=0 for the low half and h=1 for the high half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqLines | input | NUM_LINES | Level-sensitive interrupt requests, asynchronous |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | ADDR_W | Register address for reads and writes |
| regWrData | input | NUM_LINES | Write data |
| regRdData | output | NUM_LINES | Read data for `regAddr`, combinational |
| irqOut | output | 1 | Combined interrupt request to the core |

## Verification
The hardest case to reach from the ports is an acknowledge that arrives in the same cycle as a line becoming visible at the synchronizer output. The bench counts edges from the line change, raises the line, and places the acknowledge write so that it is captured on the same edge that first loads the bit. It then drops the line and confirms that the bit survives. Counter wrap cannot be reached at the default width, so a second instance with a two-bit counter shares the stimulus and is pulsed past its maximum.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Strobes from the register decode to the datapath
  typedef struct packed {
    logic maskWr;   // replace mask with write data
    logic pendAck;  // write-one-to-clear on pending
  } regStrobe_t;

  localparam int unsigned ADDR_MASK  = 0;
  localparam int unsigned ADDR_PEND  = 1;
  localparam int unsigned ADDR_LEVEL = 2;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe
);
  always_comb begin
    strobe = '0;
    if (regWrEn) begin
      strobe.maskWr  = (regAddr == ADDR_W'(ADDR_MASK));
      strobe.pendAck = (regAddr == ADDR_W'(ADDR_PEND));
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int CNT_W       = 64,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  regStrobe_t           strobe,
  input  logic [NUM_LINES-1:0] wrData,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [NUM_LINES-1:0] rdData,
  output logic [NUM_LINES-1:0] maskQ,
  output logic [NUM_LINES-1:0] pendQ,
  output logic [NUM_LINES-1:0] levelQ,
  output logic                 irqOut
);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int WIDE_W = 2 * NUM_LINES;

  logic [NUM_LINES-1:0] levelPrev;
  logic [NUM_LINES-1:0] riseVec;
  logic [NUM_LINES-1:0] ackVec;
  logic [CNT_W-1:0]     cntQ [NUM_LINES];

  irqc_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(lineIn), .syncOut(levelQ)
  );

  assign riseVec = levelQ & ~levelPrev;
  assign ackVec  = strobe.pendAck ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelPrev <= '0;
      pendQ     <= '0;
      maskQ     <= '0;
      irqOut    <= 1'b0;
    end else begin
      levelPrev <= levelQ;
      // clear first, then the live levels win
      pendQ     <= (pendQ & ~ackVec) | levelQ;
      if (strobe.maskWr) maskQ <= wrData;
      irqOut    <= |(pendQ & maskQ);
    end
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           cntQ[n] <= '0;
      else if (riseVec[n]) cntQ[n] <= cntQ[n] + 1'b1;
    end
  end

  logic [WIDE_W-1:0] cntWide;
  logic [IDX_W-1:0]  cntIdx;

  assign cntIdx = rdAddr[IDX_W:1];

  always_comb begin
    cntWide = '0;
    cntWide[CNT_W-1:0] = cntQ[cntIdx];
  end

  always_comb begin
    rdData = '0;
    if (rdAddr[ADDR_W-1]) begin
      rdData = rdAddr[0] ? cntWide[WIDE_W-1:NUM_LINES] : cntWide[NUM_LINES-1:0];
    end else begin
      case (rdAddr)
        ADDR_W'(ADDR_MASK):  rdData = maskQ;
        ADDR_W'(ADDR_PEND):  rdData = pendQ;
        ADDR_W'(ADDR_LEVEL): rdData = levelQ;
        default:             rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_pending_ctrl.sv
module irq_pending_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_LINES   = 32,  // power of two
  parameter int CNT_W       = 64,  // at most 2*NUM_LINES
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(NUM_LINES) + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [NUM_LINES-1:0] regWrData,
  output logic [NUM_LINES-1:0] regRdData,
  output logic                 irqOut
);
  regStrobe_t           strobe;
  logic [NUM_LINES-1:0] maskQ;
  logic [NUM_LINES-1:0] pendQ;
  logic [NUM_LINES-1:0] levelQ;

  irqc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .strobe(strobe)
  );

  irqc_datapath #(
    .NUM_LINES(NUM_LINES), .CNT_W(CNT_W),
    .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .lineIn(irqLines), .strobe(strobe),
    .wrData(regWrData), .rdAddr(regAddr), .rdData(regRdData),
    .maskQ(maskQ), .pendQ(pendQ), .levelQ(levelQ), .irqOut(irqOut)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 irqOut,
  input logic [NUM_LINES-1:0] maskQ,
  input logic [NUM_LINES-1:0] pendQ,
  input logic [NUM_LINES-1:0] levelQ,
  input regStrobe_t           strobe,
  input logic [NUM_LINES-1:0] wrData
);
  // R1: a pending bit only falls when an acknowledge was issued
  a_r1_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(pendQ) & ~pendQ)) |-> $past(strobe.pendAck));

  // R4: a live synchronized level always lands in pending
  a_r4_level_wins: assert property (@(posedge clk) disable iff (!rstN)
    ((pendQ & $past(levelQ)) == $past(levelQ)));

  // R3: acknowledged bits whose line was low are clear afterwards
  a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pendAck |=> ((pendQ & $past(wrData) & ~$past(levelQ)) == '0));

  // R5: a mask write loads the whole word
  a_r5_mask_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskWr |=> (maskQ == $past(wrData)));

  // R2: an all-zero mask keeps the output low on the next cycle
  a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ($past(maskQ) == '0) |-> !irqOut);
endmodule

bind irq_pending_ctrl irqc_checker #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rstN(rstN), .irqOut(irqOut), .maskQ(maskQ), .pendQ(pendQ),
  .levelQ(levelQ), .strobe(strobe), .wrData(regWrData)
);

// File: tb/irq_pending_ctrl_bench.sv
module irq_pending_ctrl_bench;
  localparam int NL = 32;
  localparam int AW = 7;
  localparam logic [AW-1:0] A_MASK = 7'd0;
  localparam logic [AW-1:0] A_PEND = 7'd1;
  localparam logic [AW-1:0] A_LVL  = 7'd2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NL-1:0] irqLines = '0;
  logic          regWrEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [NL-1:0] regWrData = '0;
  logic [NL-1:0] regRdData;
  logic [NL-1:0] smallRd;
  logic          irqOut;
  logic          smallIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_pending_ctrl u_irq_pending_ctrl (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut)
  );

  // narrow counters so that wrap can be reached
  irq_pending_ctrl #(.CNT_W(2)) u_small (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(smallRd),
    .irqOut(smallIrq)
  );

  // {lines[31:0], op[1:0] (1 = mask write, 2 = acknowledge), data[31:0]}
  localparam logic [65:0] VEC [8] = '{
    {32'h0000_0001, 2'd1, 32'h0000_0001},
    {32'h0000_0000, 2'd2, 32'h0000_0001},
    {32'h8000_0000, 2'd0, 32'h0000_0000},
    {32'h8000_0000, 2'd1, 32'h8000_0000},
    {32'h8000_0000, 2'd2, 32'h8000_0000},
    {32'h0000_00F0, 2'd2, 32'hFFFF_FFFF},
    {32'h0000_0000, 2'd1, 32'h0000_0010},
    {32'h0000_0000, 2'd2, 32'h0000_0030}
  };

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [NL-1:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick(1);
    regWrEn = 1'b0;
  endtask

  task automatic pulse(input int line);
    irqLines[line] = 1'b1; tick(3);
    irqLines[line] = 1'b0; tick(3);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    logic [NL-1:0] d;
    logic [NL-1:0] mdlPend;
    logic [NL-1:0] mdlMask;
    mdlPend = '0; mdlMask = '0;
    tick(3);
    // R6: state while held in reset
    rd(A_MASK, d); check("R6 mask at reset", 64'(d), 64'd0);
    rd(A_PEND, d); check("R6 pending at reset", 64'(d), 64'd0);
    check("R6 irqOut at reset", 64'(irqOut), 64'd0);
    rd(7'd64, d); check("R6 counter at reset", 64'(d), 64'd0);
    rstN = 1'b1;
    tick(2);

    // vector table: R1 R2 R3 R4 R5
    foreach (VEC[k]) begin
      logic [31:0] lines, data;
      logic [1:0]  op;
      {lines, op, data} = VEC[k];
      irqLines = lines;
      tick(4);
      mdlPend |= lines;
      if (op == 2'd1) begin wr(A_MASK, data); mdlMask = data; end
      if (op == 2'd2) begin wr(A_PEND, data); mdlPend = (mdlPend & ~data) | lines; end
      tick(3);
      rd(A_PEND, d); check($sformatf("R1/R3/R4 pending vec %0d", k), 64'(d), 64'(mdlPend));
      rd(A_MASK, d); check($sformatf("R5 mask vec %0d", k), 64'(d), 64'(mdlMask));
      check($sformatf("R2 irqOut vec %0d", k), 64'(irqOut), 64'(|(mdlPend & mdlMask)));
    end
    // now pending = 0xC0, mask = 0x10
    rd(A_PEND, d); check("R5 repeated read has no effect", 64'(d), 64'h0000_00C0);

    // R1 and R2 latency for line 12
    wr(A_MASK, 32'h0000_1000);
    tick(2);
    irqLines[12] = 1'b1;
    tick(2);
    rd(A_PEND, d); check("R1 not yet pending after 2 edges", 64'(d[12]), 64'd0);
    rd(A_LVL, d);  check("R9 level read shows line 12", 64'(d), 64'h0000_1000);
    tick(1);
    rd(A_PEND, d); check("R1 pending after 3 edges", 64'(d[12]), 64'd1);
    check("R2 irqOut still low after 3 edges", 64'(irqOut), 64'd0);
    tick(1);
    check("R2 irqOut high after 4 edges", 64'(irqOut), 64'd1);
    irqLines[12] = 1'b0;
    tick(5);
    wr(A_PEND, 32'h0000_1000);
    rd(A_PEND, d); check("R3 ack clears released line", 64'(d[12]), 64'd0);
    tick(1);
    check("R2 irqOut low one cycle after clear", 64'(irqOut), 64'd0);

    // R4: acknowledge captured on the edge that first loads the bit
    irqLines[9] = 1'b1;
    tick(2);
    wr(A_PEND, 32'h0000_0200);
    irqLines[9] = 1'b0;
    tick(5);
    rd(A_PEND, d); check("R4 same-cycle ack loses to new level", 64'(d[9]), 64'd1);

    // R7 counters
    rd(7'd64 + 7'd62, d); check("R7 held line 31 counted once", 64'(d), 64'd1);
    rd(7'd64 + 7'd63, d); check("R9 counter 31 high half", 64'(d), 64'd0);
    rd(7'd64 + 7'd0, d);  check("R7 line 0 count", 64'(d), 64'd1);
    for (int p = 0; p < 3; p++) pulse(2);
    rd(7'd64 + 7'd4, d); check("R7 three pulses on line 2", 64'(d), 64'd3);
    check("R8 narrow counter at max", 64'(smallRd), 64'd3);
    pulse(2);
    rd(7'd64 + 7'd4, d); check("R7 four pulses on line 2", 64'(d), 64'd4);
    check("R8 narrow counter wrapped", 64'(smallRd), 64'd0);

    // R6 reset in mid-run
    rstN = 1'b0;
    tick(2);
    rd(7'd64 + 7'd4, d); check("R6 counter cleared", 64'(d), 64'd0);
    rd(A_MASK, d); check("R6 mask cleared", 64'(d), 64'd0);
    rd(A_PEND, d); check("R6 pending cleared", 64'(d), 64'd0);
    check("R6 irqOut cleared", 64'(irqOut), 64'd0);
    finish();
  end
endmodule